// File: doc/BRIEF.md
# Hysteresis Trigger with Hold Times

This block watches a stream of 8-bit samples and emits a single-cycle trigger pulse when the stream meets a programmed condition. It can also watch an external digital line. Four 16-bit channels arrive in parallel. A four-way selector maps either the upper or the lower byte of any channel onto each of its outputs. A second control then picks which selector output the trigger logic observes.

The main mode is a comparator with hysteresis. The signal counts as low when it sits at or below the low threshold, and as high when it sits at or above the high threshold. Each of these states only counts as established after it has held for a programmed number of valid samples. Normal modes fire when the opposite state becomes established after an established start state. Glitch modes fire when a state ends before reaching its hold time. Digital modes compare the byte against a masked pattern and fire on entry to, or exit from, a match. External modes detect an edge on the synchronized external input.

A capture controller would drive the thresholds and hold times from its registers and use the pulse to freeze its sample memory.

Top module: `hyst_trigger`

## Requirements
- R1: The mode code `trig_type` selects the mode: 0 external rising, 1 external falling, 2 normal rising, 3 normal falling, 4 glitch rising, 5 glitch falling, 6 digital arrive, 7 digital leave. In modes 0 and 1, `ext_trig` passes through two synchronizing flops before edge detection. A change applied before clock edge k appears on `trig_o` after edge k+2.
- R2: Field g of `sel_cfg` (bits 3g+2..3g) sets selector output g. Codes 0-3 take the upper byte (bits 15..8) of channel 0-3, and codes 4-7 take the lower byte (bits 7..0) of channel 0-3. Channel n occupies `ch_bus` bits 16n+15..16n. `trig_src` picks which selector output feeds the trigger logic.
- R3: In normal rising mode, a pulse follows the valid sample on which a run of consecutive samples at or above `lvl_hi` reaches max(`hold_hi`,1), provided an established low state came first.
- R4: The low state is established on the valid sample at which a run of consecutive samples at or below `lvl_lo` reaches max(`hold_lo`,1).
- R5: Normal falling mode mirrors R3: it needs an established high state, then fires when the low state becomes established.
- R6: Glitch rising fires on the valid sample that ends a run at or above `lvl_hi` whose length was below `hold_hi`, provided an established low state came first. Glitch falling mirrors this with `lvl_lo` and `hold_lo`.
- R7: In digital modes, a sample matches when ((sample XOR `lvl_hi`) AND `lvl_lo`) is zero. Arrive fires on a match that follows a non-match, and leave fires on a non-match that follows a match. No prior match is assumed after reset.
- R8: Cycles with `smp_vld` low have no effect on the run counts, on the established states, or on the pulse in modes 2-7.
- R9: Run counters saturate at 2^TW-1 and never wrap.
- R10: `trig_o` is low in reset and is a one-cycle pulse, registered one cycle after the sample edge that causes it. Without an established start state, modes 2-5 never fire.
- R11: After a pulse in a normal or glitch mode, the start state must be established again before the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Sample strobe |
| ch_bus | input | 64 | Four 16-bit channels, channel n at bits 16n+15..16n |
| sel_cfg | input | 12 | Four 3-bit selector codes |
| trig_src | input | 2 | Selector output feeding the trigger |
| trig_type | input | 3 | Mode code |
| lvl_lo | input | 8 | Low threshold, or mask in digital modes |
| lvl_hi | input | 8 | High threshold, or pattern in digital modes |
| hold_lo | input | 16 | Minimum low run in samples |
| hold_hi | input | 16 | Minimum high run in samples |
| ext_trig | input | 1 | Asynchronous external trigger line |
| trig_o | output | 1 | Trigger pulse |

## Verification
The bench sweeps hold times against run lengths one sample on either side of the threshold. An off-by-one in the run comparison would fire one sample early, or would miss runs of exactly the hold length. It sweeps every selector code on every selector output, with a single byte toggling: a swapped upper/lower byte or a mis-indexed channel gives no pulse. A 66,000-sample high run under a glitch mode catches a wrapping counter, which would report a false glitch. Interleaved invalid low samples, re-arming after a pulse, and the external synchronizer latency are also checked. A design that counted strobe-less cycles, stayed armed after firing, or dropped a flop would show up as a wrong pulse count or a wrong pulse cycle.

// File: rtl/hyst_trigger.sv
module hyst_trigger #(
  parameter int SW   = 8,
  parameter int NSEL = 4,
  parameter int TW   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_vld,
  input  logic [NSEL*2*SW-1:0]       ch_bus,
  input  logic [NSEL*($clog2(NSEL)+1)-1:0] sel_cfg,
  input  logic [$clog2(NSEL)-1:0]    trig_src,
  input  logic [2:0]                 trig_type,
  input  logic [SW-1:0]              lvl_lo,
  input  logic [SW-1:0]              lvl_hi,
  input  logic [TW-1:0]              hold_lo,
  input  logic [TW-1:0]              hold_hi,
  input  logic                       ext_trig,
  output logic                       trig_o
);
  localparam int CW   = 2 * SW;
  localparam int SRCW = $clog2(NSEL);
  localparam int CSW  = SRCW + 1;
  localparam logic [TW-1:0] CMAX = {TW{1'b1}};

  localparam logic [2:0] T_EXT_R = 3'd0, T_EXT_F = 3'd1, T_NRM_R = 3'd2, T_NRM_F = 3'd3,
                         T_GL_R  = 3'd4, T_GL_F  = 3'd5, T_DIG_A = 3'd6, T_DIG_L = 3'd7;

  logic [SW-1:0] sel_out [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    logic [CSW-1:0]  code;
    logic [SRCW-1:0] chn;
    assign code = sel_cfg[g*CSW +: CSW];
    assign chn  = code[SRCW-1:0];
    assign sel_out[g] = code[CSW-1] ? ch_bus[int'(chn)*CW +: SW]
                                    : ch_bus[int'(chn)*CW + SW +: SW];
  end

  logic [SW-1:0] smp;
  assign smp = sel_out[trig_src];

  logic [TW-1:0] lo_cnt, hi_cnt, lo_run, hi_run;
  logic          armed_lo, armed_hi, match_q;
  logic [2:0]    ext_s;

  logic is_lo, is_hi, lo_ok, hi_ok, match, fire;
  assign is_lo  = smp <= lvl_lo;
  assign is_hi  = smp >= lvl_hi;
  assign lo_run = !is_lo ? '0 : (lo_cnt == CMAX) ? CMAX : lo_cnt + TW'(1);
  assign hi_run = !is_hi ? '0 : (hi_cnt == CMAX) ? CMAX : hi_cnt + TW'(1);
  assign lo_ok  = is_lo && (lo_run >= hold_lo);
  assign hi_ok  = is_hi && (hi_run >= hold_hi);
  assign match  = ((smp ^ lvl_hi) & lvl_lo) == '0;

  always_comb begin
    case (trig_type)
      T_EXT_R: fire = ext_s[1] & ~ext_s[2];
      T_EXT_F: fire = ~ext_s[1] & ext_s[2];
      T_NRM_R: fire = smp_vld & armed_lo & hi_ok;
      T_NRM_F: fire = smp_vld & armed_hi & lo_ok;
      T_GL_R:  fire = smp_vld & armed_lo & !is_hi & (hi_cnt != '0) & (hi_cnt < hold_hi);
      T_GL_F:  fire = smp_vld & armed_hi & !is_lo & (lo_cnt != '0) & (lo_cnt < hold_lo);
      T_DIG_A: fire = smp_vld & match & ~match_q;
      default: fire = smp_vld & ~match & match_q;
    endcase
  end

  logic clr_lo, clr_hi;
  assign clr_lo = fire && (trig_type == T_NRM_R || trig_type == T_GL_R);
  assign clr_hi = fire && (trig_type == T_NRM_F || trig_type == T_GL_F);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt   <= '0;
      hi_cnt   <= '0;
      armed_lo <= 1'b0;
      armed_hi <= 1'b0;
      match_q  <= 1'b0;
      ext_s    <= '0;
      trig_o   <= 1'b0;
    end else begin
      ext_s  <= {ext_s[1:0], ext_trig};
      trig_o <= fire;
      if (smp_vld) begin
        lo_cnt   <= lo_run;
        hi_cnt   <= hi_run;
        match_q  <= match;
        armed_lo <= lo_ok | (armed_lo & ~clr_lo);
        armed_hi <= hi_ok | (armed_hi & ~clr_hi);
      end
    end
  end
endmodule

module hyst_trigger_chk #(
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_vld,
  input logic [2:0]    trig_type,
  input logic [SW-1:0] smp,
  input logic [SW-1:0] lvl_lo,
  input logic [SW-1:0] lvl_hi,
  input logic          ext_trig,
  input logic          trig_o
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o); // R10
  AST_NO_FIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && trig_type >= 3'd2) |=> !trig_o); // R8
  AST_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && trig_type == 3'd2 && smp < lvl_hi) |=> !trig_o); // R3
  AST_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && trig_type == 3'd3 && smp > lvl_lo) |=> !trig_o); // R5
  AST_GLITCH_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && trig_type == 3'd4 && smp >= lvl_hi) |=> !trig_o); // R6
  AST_EXT_LEVEL_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && $past(trig_type) == 3'd0) |-> $past(ext_trig, 3)); // R1
endmodule

bind hyst_trigger hyst_trigger_chk #(.SW(SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .trig_type(trig_type), .smp(smp),
  .lvl_lo(lvl_lo), .lvl_hi(lvl_hi), .ext_trig(ext_trig), .trig_o(trig_o));

// File: tb/hyst_trigger_tb.sv
module hyst_trigger_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_vld = 1'b0;
  logic [63:0] ch_bus = '0;
  logic [11:0] sel_cfg = '0;
  logic [1:0]  trig_src = '0;
  logic [2:0]  trig_type = '0;
  logic [7:0]  lvl_lo = 8'h40, lvl_hi = 8'hC0;
  logic [15:0] hold_lo = '0, hold_hi = '0;
  logic        ext_trig = 1'b0;
  logic        trig_o;

  int n_chk = 0, n_fail = 0, pulses = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hyst_trigger dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .ch_bus(ch_bus), .sel_cfg(sel_cfg),
    .trig_src(trig_src), .trig_type(trig_type), .lvl_lo(lvl_lo), .lvl_hi(lvl_hi),
    .hold_lo(hold_lo), .hold_hi(hold_hi), .ext_trig(ext_trig), .trig_o(trig_o));

  always @(negedge clk) begin
    cyc++;
    if (trig_o) pulses++;
    if (cyc > 190000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; smp_vld = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; pulses = 0;
  endtask

  task automatic put(logic [7:0] b, logic v);
    @(negedge clk);
    ch_bus[15:8] = b; smp_vld = v;
    @(posedge clk);
  endtask

  task automatic idle(int n);
    @(negedge clk); smp_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(logic [2:0] t, logic [15:0] hl, logic [15:0] hh);
    trig_type = t; hold_lo = hl; hold_hi = hh;
    sel_cfg = '0; trig_src = '0; ch_bus = '0;
    do_reset();
  endtask

  initial begin
    // R10: reset state and no pulse before the start state exists
    setup(3'd2, 16'd0, 16'd0);
    chk("R10 reset", int'(trig_o), 0);
    for (int i = 0; i < 5; i++) put(8'hF0, 1'b1);
    idle(2);
    chk("R10 unarmed", pulses, 0);

    // R10 latency: pulse right after the edge taking the high sample
    setup(3'd2, 16'd0, 16'd0);
    put(8'h10, 1'b1);
    put(8'hF0, 1'b1);
    @(negedge clk);
    chk("R10 latency", int'(trig_o), 1);
    idle(2);

    // R2: every selector code on every selector output
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 8; c++) begin
        int off;
        setup(3'd2, 16'd0, 16'd0);
        for (int g = 0; g < 4; g++) sel_cfg[g*3 +: 3] = (g == s) ? 3'(c) : 3'((c + 1) % 8);
        trig_src = 2'(s);
        off = (c % 4) * 16 + ((c < 4) ? 8 : 0);
        ch_bus = {8{8'h80}};
        foreach (ch_bus[i]) ;
        @(negedge clk); ch_bus[off +: 8] = 8'h10; smp_vld = 1'b1; @(posedge clk);
        @(negedge clk); ch_bus[off +: 8] = 8'hF0; @(posedge clk);
        @(negedge clk); ch_bus[off +: 8] = 8'h10; @(posedge clk);
        idle(2);
        chk($sformatf("R2 src%0d code%0d", s, c), pulses, 1);
      end

    // R3: high hold against high run length
    for (int h = 0; h < 6; h++)
      for (int l = 1; l < 7; l++) begin
        setup(3'd2, 16'd0, 16'(h));
        put(8'h10, 1'b1);
        for (int i = 0; i < l; i++) put(8'hF0, 1'b1);
        put(8'h10, 1'b1);
        idle(2);
        chk($sformatf("R3 hold%0d run%0d", h, l), pulses, (l >= ((h < 1) ? 1 : h)) ? 1 : 0);
      end

    // R4: low hold against low run length
    for (int h = 0; h < 5; h++)
      for (int l = 1; l < 5; l++) begin
        setup(3'd2, 16'(h), 16'd0);
        for (int i = 0; i < l; i++) put(8'h20, 1'b1);
        put(8'hE0, 1'b1);
        idle(2);
        chk($sformatf("R4 hold%0d run%0d", h, l), pulses, (l >= ((h < 1) ? 1 : h)) ? 1 : 0);
      end

    // R5: normal falling
    setup(3'd3, 16'd2, 16'd0);
    put(8'hF0, 1'b1); put(8'h10, 1'b1); put(8'hF0, 1'b1);
    idle(2);
    chk("R5 short low", pulses, 0);
    put(8'h10, 1'b1); put(8'h10, 1'b1);
    idle(2);
    chk("R5 qualified low", pulses, 1);

    // R6: glitch rising sweep
    for (int h = 0; h < 6; h++)
      for (int l = 1; l < 7; l++) begin
        setup(3'd4, 16'd0, 16'(h));
        put(8'h10, 1'b1);
        for (int i = 0; i < l; i++) put(8'hF0, 1'b1);
        put(8'h10, 1'b1);
        idle(2);
        chk($sformatf("R6 rise hold%0d run%0d", h, l), pulses, (l < h) ? 1 : 0);
      end
    // R6: glitch falling
    setup(3'd5, 16'd3, 16'd0);
    put(8'hF0, 1'b1); put(8'h10, 1'b1); put(8'h10, 1'b1); put(8'hF0, 1'b1);
    idle(2);
    chk("R6 fall short", pulses, 1);
    setup(3'd5, 16'd3, 16'd0);
    put(8'hF0, 1'b1); put(8'h10, 1'b1); put(8'h10, 1'b1); put(8'h10, 1'b1); put(8'hF0, 1'b1);
    idle(2);
    chk("R6 fall long", pulses, 0);

    // R7: digital arrive and leave, mask F0, pattern A5
    for (int m = 0; m < 2; m++) begin
      setup(3'(6 + m), 16'd0, 16'd0);
      lvl_lo = 8'hF0; lvl_hi = 8'hA5;
      put(8'h00, 1'b1); put(8'hA0, 1'b1); put(8'hAF, 1'b1); put(8'h3A, 1'b1); put(8'hA1, 1'b1);
      idle(2);
      chk(m == 0 ? "R7 arrive" : "R7 leave", pulses, m == 0 ? 2 : 1);
      lvl_lo = 8'h40; lvl_hi = 8'hC0;
    end

    // R8: invalid low samples inside a high run are ignored
    setup(3'd2, 16'd0, 16'd3);
    put(8'h10, 1'b1); put(8'hF0, 1'b1); put(8'h10, 1'b0); put(8'hF0, 1'b1);
    put(8'h10, 1'b0);
    idle(2);
    chk("R8 before third", pulses, 0);
    put(8'hF0, 1'b1);
    idle(2);
    chk("R8 third valid high", pulses, 1);

    // R11: rearm needs a new qualified low
    setup(3'd2, 16'd3, 16'd0);
    put(8'h10, 1'b1); put(8'h10, 1'b1); put(8'h10, 1'b1); put(8'hF0, 1'b1);
    put(8'h10, 1'b1); put(8'hF0, 1'b1);
    idle(2);
    chk("R11 not rearmed", pulses, 1);
    put(8'h10, 1'b1); put(8'h10, 1'b1); put(8'h10, 1'b1); put(8'hF0, 1'b1);
    idle(2);
    chk("R11 rearmed", pulses, 2);

    // R1: external edges through the synchronizer
    setup(3'd0, 16'd0, 16'd0);
    @(negedge clk); ext_trig = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R1 rise early", int'(trig_o), 0);
    @(posedge clk); @(negedge clk);
    chk("R1 rise third edge", int'(trig_o), 1);
    ext_trig = 1'b0;
    idle(5);
    chk("R1 rise count", pulses, 1);
    trig_type = 3'd1; ext_trig = 1'b1;
    do_reset();
    idle(5);
    ext_trig = 1'b0;
    idle(5);
    chk("R1 fall count", pulses, 1);

    // R9: saturating counters over a very long run
    setup(3'd4, 16'd0, 16'hFFFF);
    put(8'h10, 1'b1);
    @(negedge clk); ch_bus[15:8] = 8'hF0; smp_vld = 1'b1;
    repeat (66000) @(posedge clk);
    put(8'h10, 1'b1);
    idle(2);
    chk("R9 no wrap glitch", pulses, 0);
    setup(3'd2, 16'd0, 16'hFFFF);
    put(8'h10, 1'b1);
    @(negedge clk); ch_bus[15:8] = 8'hF0; smp_vld = 1'b1;
    repeat (65535) @(posedge clk);
    idle(2);
    chk("R9 max hold reached", pulses, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule